// File: doc/BRIEF.md
# SDRAM Activate Timing Guard

This block sits in the command path of an SDRAM controller. Each clock it looks at one requested command (ACTIVATE, READ, WRITE or PRECHARGE, with a bank and a row) and answers at once whether that command may go to the memory in this cycle. It keeps an open flag and the open row for every bank, along with per-bank countdowns. It also keeps a shared cross-bank activate spacing counter and, on eight-bank parts, a window that admits at most four activates.

Every timing limit is a parameter in whole clock cycles. The integrator converts each nanosecond limit by dividing it by the clock period and rounding up. For example, 20 ns at a 3.75 ns clock gives 5.33, which becomes 6 cycles. Grant is combinational from the registered state, and a granted command updates that state on the next rising edge. A request that is stalled must be held by the requester until it is granted. A request that breaks the open-row protocol raises a protocol-error output and is never granted.

Top module: `sdram_act_guard`

## Requirements
- R1: After reset every bank is closed, `bank_open` is all zero, and all timers are clear, so an ACTIVATE in the first cycle after reset is granted.
- R2: Command codes on `req_cmd` are 00 ACTIVATE, 01 READ, 10 WRITE and 11 PRECHARGE. An ACTIVATE to a closed bank whose timers allow it is granted, and that bank's `bank_open` bit is 1 from the next cycle on.
- R3: A READ or WRITE to a closed bank, or to an open bank with a row other than the open row, is not granted and raises `proto_err` in the same cycle.
- R4: A READ or WRITE to the open row is granted no earlier than T_RCD cycles after that bank's ACTIVATE, and is granted from that cycle on.
- R5: An ACTIVATE to a bank that is already open is not granted and raises `proto_err`.
- R6: A valid PRECHARGE is always granted and clears that bank's `bank_open` bit from the next cycle. A PRECHARGE to a closed bank leaves `bank_open` unchanged.
- R7: Two ACTIVATEs to the same bank are at least T_RC cycles apart.
- R8: Two ACTIVATEs to any banks are at least T_RRD cycles apart.
- R9: When NUM_BANKS is 8, no more than four ACTIVATEs are granted within any T_FAW consecutive cycles. A further ACTIVATE is granted as soon as the oldest of the last four is T_FAW cycles old.
- R10: While `req_valid` is low, `grant` and `proto_err` are both low and no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 2 | Command code (00 ACT, 01 READ, 10 WRITE, 11 PRE) |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Row address (opened by ACT, matched by READ/WRITE) |
| grant | output | 1 | Command may issue this cycle |
| proto_err | output | 1 | Request breaks the open-row protocol |
| bank_open | output | NUM_BANKS | Per-bank open flag |

## Verification
The bench builds the guard with eight banks, so the four-activate window is in place. It uses short limits: T_RCD=3, T_RC=7, T_RRD=2 and T_FAW=10. With T_RRD this short, four activates fit inside one window with room to spare. That lets a fifth activate be held back by the window alone, and then released on the exact cycle the oldest activate ages out. The small row range (two rows in the random phase) makes row hits, row misses and re-activations of the same bank frequent. A scoreboard of last-issue cycle numbers then judges every random cycle.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;
endpackage

// File: rtl/act_bank_state.sv
// Open-row state and the two per-bank countdowns of one bank.
module act_bank_state #(
  parameter int ROW_W = 14,
  parameter int T_RCD = 6,
  parameter int T_RC  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_fire,
  input  logic             rw_fire,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rcd_ok,
  output logic             rc_ok
);
  localparam int RCD_W = (T_RCD > 1) ? $clog2(T_RCD) : 1;
  localparam int RC_W  = (T_RC  > 1) ? $clog2(T_RC)  : 1;
  localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(T_RCD - 1);
  localparam logic [RC_W-1:0]  RC_LOAD  = RC_W'(T_RC - 1);

  logic [RCD_W-1:0] rcd_cnt;
  logic [RC_W-1:0]  rc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (act_fire) begin
      is_open  <= 1'b1;
      open_row <= row_in;
    end else if (pre_fire) begin
      is_open  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcd_cnt <= '0;
      rc_cnt  <= '0;
    end else if (act_fire) begin
      rcd_cnt <= RCD_LOAD;
      rc_cnt  <= RC_LOAD;
    end else begin
      if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
      if (rc_cnt  != '0) rc_cnt  <= rc_cnt  - 1'b1;
    end
  end

  assign rcd_ok = (rcd_cnt == '0);
  assign rc_ok  = (rc_cnt  == '0);

  // R4
  rcd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    rw_fire |-> (rcd_cnt == '0) && is_open);
  // R7
  rc_wait_chk: assert property (@(posedge clk) disable iff (rst)
    act_fire |-> (rc_cnt == '0) && !is_open);
endmodule

// File: rtl/act_spacing.sv
// Cross-bank activate spacing and the rolling activate window.
module act_spacing #(
  parameter int T_RRD    = 3,
  parameter int T_FAW    = 14,
  parameter int WIN_ACTS = 4,
  parameter bit USE_FAW  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic act_fire,
  output logic act_ok
);
  localparam int RRD_W = (T_RRD > 1) ? $clog2(T_RRD) : 1;
  localparam logic [RRD_W-1:0] RRD_LOAD = RRD_W'(T_RRD - 1);

  logic [RRD_W-1:0] rrd_cnt;
  logic             win_ok;

  always_ff @(posedge clk) begin
    if (rst)                  rrd_cnt <= '0;
    else if (act_fire)        rrd_cnt <= RRD_LOAD;
    else if (rrd_cnt != '0)   rrd_cnt <= rrd_cnt - 1'b1;
  end

  generate
    if (USE_FAW) begin : g_win
      localparam int FAW_W = (T_FAW > 1) ? $clog2(T_FAW) : 1;
      localparam logic [FAW_W-1:0] FAW_LOAD = FAW_W'(T_FAW - 1);
      logic [FAW_W-1:0]    slot_cnt [WIN_ACTS];
      logic [WIN_ACTS-1:0] slot_free;
      logic [WIN_ACTS-1:0] load_sel;

      always_comb begin
        for (int s = 0; s < WIN_ACTS; s++) slot_free[s] = (slot_cnt[s] == '0);
      end

      always_comb begin
        logic found;
        found    = 1'b0;
        load_sel = '0;
        for (int s = 0; s < WIN_ACTS; s++) begin
          if (!found && slot_free[s]) begin
            load_sel[s] = 1'b1;
            found       = 1'b1;
          end
        end
      end

      for (genvar s = 0; s < WIN_ACTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
          if (rst)                        slot_cnt[s] <= '0;
          else if (act_fire && load_sel[s]) slot_cnt[s] <= FAW_LOAD;
          else if (!slot_free[s])         slot_cnt[s] <= slot_cnt[s] - 1'b1;
        end
      end

      assign win_ok = |slot_free;

      // R9
      faw_slot_chk: assert property (@(posedge clk) disable iff (rst)
        act_fire |-> $onehot(load_sel));
    end else begin : g_nowin
      assign win_ok = 1'b1;
    end
  endgenerate

  assign act_ok = win_ok && (rrd_cnt == '0);

  // R8
  rrd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    act_fire |-> (rrd_cnt == '0));
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import act_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int T_RCD     = 6,
  parameter int T_RC      = 15,
  parameter int T_RRD     = 3,
  parameter int T_FAW     = 14,
  parameter int WIN_ACTS  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_cmd,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_row,
  output logic                 grant,
  output logic                 proto_err,
  output logic [NUM_BANKS-1:0] bank_open
);
  localparam bit USE_FAW = (NUM_BANKS == 8);

  cmd_e                           cmd;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_rows;
  logic [NUM_BANKS-1:0]           rcd_ok_v, rc_ok_v;
  logic [NUM_BANKS-1:0]           act_fire_v, rw_fire_v, pre_fire_v;
  logic                           act_ok, any_act_fire;
  logic                           sel_open, row_hit;

  assign cmd      = cmd_e'(req_cmd);
  assign sel_open = bank_open[req_bank];
  assign row_hit  = (open_rows[req_bank] == req_row);

  always_comb begin
    grant     = 1'b0;
    proto_err = 1'b0;
    if (req_valid) begin
      unique case (cmd)
        CMD_ACT: begin
          if (sel_open) proto_err = 1'b1;
          else          grant = rc_ok_v[req_bank] && act_ok;
        end
        CMD_RD, CMD_WR: begin
          if (!sel_open || !row_hit) proto_err = 1'b1;
          else                       grant = rcd_ok_v[req_bank];
        end
        CMD_PRE: grant = 1'b1;
        default: grant = 1'b0;
      endcase
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit           = grant && (req_bank == BANK_W'(b));
      assign act_fire_v[b] = hit && (cmd == CMD_ACT);
      assign rw_fire_v[b]  = hit && ((cmd == CMD_RD) || (cmd == CMD_WR));
      assign pre_fire_v[b] = hit && (cmd == CMD_PRE);

      act_bank_state #(
        .ROW_W (ROW_W),
        .T_RCD (T_RCD),
        .T_RC  (T_RC)
      ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .act_fire (act_fire_v[b]),
        .rw_fire  (rw_fire_v[b]),
        .pre_fire (pre_fire_v[b]),
        .row_in   (req_row),
        .is_open  (bank_open[b]),
        .open_row (open_rows[b]),
        .rcd_ok   (rcd_ok_v[b]),
        .rc_ok    (rc_ok_v[b])
      );
    end
  endgenerate

  assign any_act_fire = |act_fire_v;

  act_spacing #(
    .T_RRD    (T_RRD),
    .T_FAW    (T_FAW),
    .WIN_ACTS (WIN_ACTS),
    .USE_FAW  (USE_FAW)
  ) u_spacing (
    .clk      (clk),
    .rst      (rst),
    .act_fire (any_act_fire),
    .act_ok   (act_ok)
  );

  // R3
  rw_open_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && ((cmd == CMD_RD) || (cmd == CMD_WR))) |-> bank_open[req_bank]);
  // R5
  act_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (cmd == CMD_ACT) && bank_open[req_bank]) |-> (!grant && proto_err));
  // R6
  pre_close_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && (cmd == CMD_PRE)) |=> !bank_open[$past(req_bank)]);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(bank_open));
  // R2
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && (cmd == CMD_ACT)) |=> bank_open[$past(req_bank)]);
endmodule

// File: tb/sdram_act_guard_tb.sv
module sdram_act_guard_tb;
  localparam int NB = 8, RW = 4;
  localparam int T_RCD = 3, T_RC = 7, T_RRD = 2, T_FAW = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [2:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic grant, proto_err;
  logic [NB-1:0] bank_open;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_act_guard #(.NUM_BANKS(NB), .ROW_W(RW), .T_RCD(T_RCD), .T_RC(T_RC),
                    .T_RRD(T_RRD), .T_FAW(T_FAW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_row(req_row), .grant(grant),
    .proto_err(proto_err), .bank_open(bank_open));

  // {valid, cmd, bank, row, exp_grant, exp_err, req_tag}
  localparam int N = 25;
  localparam logic [15:0] TBL [N] = '{
    {1'b1,2'd0,3'd0,4'd5,1'b1,1'b0,4'd1},  // R1 ACT b0 right after reset
    {1'b1,2'd0,3'd1,4'd1,1'b0,1'b0,4'd8},  // R8 too close
    {1'b1,2'd0,3'd1,4'd1,1'b1,1'b0,4'd8},  // R8 exactly T_RRD
    {1'b1,2'd1,3'd0,4'd5,1'b1,1'b0,4'd4},  // R4 READ at T_RCD
    {1'b1,2'd0,3'd2,4'd2,1'b1,1'b0,4'd2},  // R2
    {1'b1,2'd1,3'd1,4'd1,1'b1,1'b0,4'd4},  // R4
    {1'b1,2'd0,3'd3,4'd3,1'b1,1'b0,4'd2},  // R2 fourth ACT
    {1'b0,2'd0,3'd4,4'd4,1'b0,1'b0,4'd10}, // R10 idle
    {1'b1,2'd0,3'd4,4'd4,1'b0,1'b0,4'd9},  // R9 window full
    {1'b1,2'd2,3'd1,4'd9,1'b0,1'b1,4'd3},  // R3 row miss
    {1'b1,2'd0,3'd4,4'd4,1'b1,1'b0,4'd9},  // R9 oldest aged out
    {1'b1,2'd0,3'd0,4'd8,1'b0,1'b1,4'd5},  // R5 ACT to open bank
    {1'b1,2'd3,3'd0,4'd0,1'b1,1'b0,4'd6},  // R6 PRE
    {1'b1,2'd1,3'd0,4'd5,1'b0,1'b1,4'd3},  // R3 closed bank
    {1'b1,2'd0,3'd0,4'd8,1'b1,1'b0,4'd2},  // R2 reopen
    {1'b1,2'd2,3'd0,4'd8,1'b0,1'b0,4'd4},  // R4
    {1'b1,2'd2,3'd0,4'd8,1'b0,1'b0,4'd4},  // R4
    {1'b1,2'd2,3'd0,4'd8,1'b1,1'b0,4'd4},  // R4
    {1'b1,2'd3,3'd0,4'd0,1'b1,1'b0,4'd6},  // R6
    {1'b1,2'd0,3'd0,4'd2,1'b0,1'b0,4'd7},  // R7 same-bank too soon
    {1'b1,2'd0,3'd0,4'd2,1'b0,1'b0,4'd7},  // R7
    {1'b1,2'd0,3'd0,4'd2,1'b1,1'b0,4'd7},  // R7 exactly T_RC
    {1'b1,2'd1,3'd0,4'd2,1'b0,1'b0,4'd4},  // R4
    {1'b1,2'd1,3'd0,4'd2,1'b0,1'b0,4'd4},  // R4
    {1'b1,2'd1,3'd0,4'd2,1'b1,1'b0,4'd4}   // R4
  };

  function automatic string tag(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] c, input logic [2:0] b, input logic [RW-1:0] r);
    req_valid = v; req_cmd = c; req_bank = b; req_row = r;
    #1;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // scoreboard of last-issue cycle numbers
  bit m_open [NB];
  int m_row [NB], m_last [NB], m_any, m_hist [4], now;

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_last[b] = -1000; end
    for (int h = 0; h < 4; h++) m_hist[h] = -1000;
    m_any = -1000; now = 0;
  endtask

  task automatic predict(input bit v, input int c, input int b, input int r,
                         output bit g, output bit e);
    int inwin;
    g = 0; e = 0;
    if (v) begin
      case (c)
        0: begin
          inwin = 0;
          for (int h = 0; h < 4; h++) if (now - m_hist[h] < T_FAW) inwin++;
          if (m_open[b]) e = 1;
          else g = (now - m_last[b] >= T_RC) && (now - m_any >= T_RRD) && (inwin < 4);
        end
        1, 2: begin
          if (!m_open[b] || m_row[b] != r) e = 1;
          else g = (now - m_last[b] >= T_RCD);
        end
        default: g = 1;
      endcase
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit eg, ee;
    logic [NB-1:0] ref_open;
    repeat (3) @(negedge clk);
    drive(1'b0, 2'd0, 3'd0, '0);
    chk("R1", "bank_open in reset", bank_open, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "bank_open after reset", bank_open, 0);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i][15], TBL[i][14:13], TBL[i][12:10], TBL[i][9:6]);
      chk(tag(TBL[i][3:0]), $sformatf("step %0d grant", i), grant, TBL[i][5]);
      chk(tag(TBL[i][3:0]), $sformatf("step %0d proto_err", i), proto_err, TBL[i][4]);
      tick();
    end
    drive(1'b0, 2'd0, 3'd0, '0);
    chk("R2", "bank_open after table", bank_open, 8'h1f);
    // R6: PRE to closed bank granted, no state change
    drive(1'b1, 2'd3, 3'd7, '0);
    chk("R6", "PRE closed grant", grant, 1);
    tick();
    drive(1'b0, 2'd0, 3'd0, '0);
    chk("R6", "PRE closed keeps open", bank_open, 8'h1f);
    // R10: valid low with an otherwise legal READ
    drive(1'b0, 2'd1, 3'd0, 4'd2);
    chk("R10", "idle grant", grant, 0);
    chk("R10", "idle err", proto_err, 0);
    tick();
    chk("R10", "idle no change", bank_open, 8'h1f);
    // R1: reset clears state, first ACT grantable
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1", "open cleared", bank_open, 0);
    drive(1'b1, 2'd0, 3'd0, 4'd2);
    chk("R1", "ACT after reset", grant, 1);
    tick();

    // random phase against the scoreboard
    rst = 1'b1; drive(1'b0, 2'd0, 3'd0, '0); tick(); rst = 1'b0;
    model_reset();
    for (int k = 0; k < 3000; k++) begin
      bit v; int c, b, r;
      v = ($urandom % 5) != 0; c = $urandom % 4; b = $urandom % NB; r = $urandom % 2;
      drive(v, c[1:0], b[2:0], r[RW-1:0]);
      for (int j = 0; j < NB; j++) ref_open[j] = m_open[j];
      chk("R6", "random bank_open", bank_open, ref_open);
      predict(v, c, b, r, eg, ee);
      chk(c == 0 ? "R9" : "R4", $sformatf("random grant cyc %0d", now), grant, eg);
      chk(c == 0 ? "R5" : "R3", $sformatf("random err cyc %0d", now), proto_err, ee);
      if (eg) begin
        if (c == 0) begin
          m_open[b] = 1; m_row[b] = r; m_last[b] = now; m_any = now;
          for (int h = 3; h > 0; h--) m_hist[h] = m_hist[h-1];
          m_hist[0] = now;
        end else if (c == 3) m_open[b] = 0;
      end
      tick();
      now++;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule